// File: doc/BRIEF.md
# Three-Plane Tile Pixel Mixer

This block sits in a video overlay pipeline after the address stage. For each incoming pixel it receives the source RGB value, the line and frame sync flags, a flag that says whether the pixel falls inside the visible overlay area, the 8-bit tile number, and the column and row offset inside that tile. It reads one bit from each of three bit-planes of the tile's bitmap to get a 3-bit code. It turns the code into a graphics colour and a blend weight, and it mixes that colour into the video per channel.

A two-bit mode input picks how the code is read. In the first mode, palette entry 0 is drawn with eight per-pixel weights, which softens edges. In the second mode, the code indexes an eight-entry palette and a global weight applies. In the third mode, code 0 lets the video through and the other codes index palette entries 1 to 7. Pixels move through with a valid/ready handshake at both ends. The bitmap store is built in as a fixed arithmetic pattern, and the pipeline holds its output while the downstream side stalls.

Top module: `tile_plane_mixer`

## Requirements
- R1: After reset, out_valid is low and in_ready is high while out_ready is high.
- R2: The built-in bitmap gives the pixel code as bits [2:0] of (3·tile + col + 2·row). Plane k supplies bit k of the code.
- R3: Every pixel accepted on the input leaves the output exactly once, in the same order, with its hsync and vsync flags unchanged. When nothing stalls, a pixel accepted on one edge is presented after the second edge that follows.
- R4: While out_valid is high and out_ready is low, out_pix, out_hs, out_vs and out_valid stay unchanged. No pixel is lost or duplicated under any pattern of stalls.
- R5: A pixel whose in_ovl flag is 0 leaves with in_pix unchanged, whatever the mode or code.
- R6: With mode 0, the colour is palette entry 0 and the weight is round(code·255/7), computed as (code·255+3)/7.
- R7: With mode 1 or 3, the colour is the palette entry selected by the code and the weight is glob_alpha.
- R8: With mode 2, code 0 outputs the video unchanged. Codes 1 to 7 use the palette entry with that index and the glob_alpha weight.
- R9: Each 8-bit channel is mixed as (a·g + (255−a)·v + 127)/255 with integer division. This gives the video at a=0 and the graphics at a=255.
- R10: With the USE_ALPHA parameter set to 0, every overlay pixel that is not transparent under R8 takes the graphics colour outright, with a weight of 255 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Code interpretation: 0 weight steps, 1/3 palette, 2 palette with transparent code 0 |
| glob_alpha | input | 8 | Global weight for modes 1, 2 and 3 |
| palette | input | 192 | Eight 24-bit colours; entry i occupies bits 24i+23 down to 24i |
| in_pix | input | 24 | Source video pixel (three 8-bit channels) |
| in_hs | input | 1 | Line sync flag travelling with the pixel |
| in_vs | input | 1 | Frame sync flag travelling with the pixel |
| in_ovl | input | 1 | 1 when the pixel is inside the visible overlay area |
| in_tile | input | 8 | Tile number from the tile buffer |
| in_col | input | TILE_LOG2 | Column offset inside the tile |
| in_row | input | TILE_LOG2 | Row offset inside the tile |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| out_pix | output | 24 | Mixed pixel |
| out_hs | output | 1 | Line sync aligned to out_pix |
| out_vs | output | 1 | Frame sync aligned to out_pix |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |

## Verification
The bench sweeps all four mode values over four global weights: 0, 255 and two midpoints. For each setting it runs several tiles, every column offset and two rows, so every code reaches every mode. The weight 0 and 255 sweeps separate the two ends of the mixing formula from a rounding error. The midpoints show whether the rounding is to nearest, because a truncating mix is off by one there. The overlay flag and the video pixels change from pixel to pixel to expose a pass-through path that leaks graphics. A pseudo-random output stall pattern, plus gaps in the input, checks ordering, sync alignment and the hold of a stalled output. A second instance with USE_ALPHA set to 0 gets the same stimulus, to tell the replace path apart from the mixing path.

// File: rtl/tile_plane_mixer.sv
module tile_plane_mixer #(
  parameter int TILE_LOG2 = 3,
  parameter bit USE_ALPHA = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [7:0]           glob_alpha,
  input  logic [191:0]         palette,
  input  logic [23:0]          in_pix,
  input  logic                 in_hs,
  input  logic                 in_vs,
  input  logic                 in_ovl,
  input  logic [7:0]           in_tile,
  input  logic [TILE_LOG2-1:0] in_col,
  input  logic [TILE_LOG2-1:0] in_row,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [23:0]          out_pix,
  output logic                 out_hs,
  output logic                 out_vs,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int SW = TILE_LOG2 + 11;

  function automatic logic [2:0] plane_code(input logic [7:0] t,
                                            input logic [TILE_LOG2-1:0] c,
                                            input logic [TILE_LOG2-1:0] r);
    logic [SW-1:0] s;
    s = SW'(t) * SW'(3) + SW'(c) + SW'(r) * SW'(2);
    return {s[2], s[1], s[0]};
  endfunction

  function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] g,
                                      input logic [7:0] v);
    logic [16:0] acc;
    acc = 17'(a) * 17'(g) + 17'(8'd255 - a) * 17'(v) + 17'd127;
    return 8'(acc / 17'd255);
  endfunction

  logic en;
  assign en = out_ready || !out_valid;
  assign in_ready = en;

  logic        v1, hs1, vs1, ovl1;
  logic [23:0] pix1;
  logic [2:0]  code1;

  logic        v2, hs2, vs2, ovl2;
  logic [23:0] vid2, col2;
  logic [7:0]  a2;

  logic [23:0] pick;
  logic [7:0]  wsel;
  logic [10:0] step;
  assign step = (11'(code1) * 11'd255 + 11'd3) / 11'd7;

  always_comb begin
    pick = palette[24*code1 +: 24];
    wsel = USE_ALPHA ? glob_alpha : 8'd255;
    case (mode)
      2'd0: begin
        pick = palette[23:0];
        wsel = USE_ALPHA ? step[7:0] : 8'd255;
      end
      2'd2: if (code1 == 3'd0) wsel = 8'd0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; hs1 <= 1'b0; vs1 <= 1'b0; ovl1 <= 1'b0; pix1 <= '0; code1 <= '0;
      v2 <= 1'b0; hs2 <= 1'b0; vs2 <= 1'b0; ovl2 <= 1'b0; vid2 <= '0; col2 <= '0; a2 <= '0;
      out_valid <= 1'b0; out_hs <= 1'b0; out_vs <= 1'b0; out_pix <= '0;
    end else if (en) begin
      v1 <= in_valid; hs1 <= in_hs; vs1 <= in_vs; ovl1 <= in_ovl; pix1 <= in_pix;
      code1 <= plane_code(in_tile, in_col, in_row);
      v2 <= v1; hs2 <= hs1; vs2 <= vs1; ovl2 <= ovl1; vid2 <= pix1; col2 <= pick;
      a2 <= ovl1 ? wsel : 8'd0;
      out_valid <= v2; out_hs <= hs2; out_vs <= vs2;
      out_pix <= !ovl2 ? vid2 :
                 {mix8(a2, col2[23:16], vid2[23:16]),
                  mix8(a2, col2[15:8],  vid2[15:8]),
                  mix8(a2, col2[7:0],   vid2[7:0])};
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_hs) && $stable(out_vs));

  // R3
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && v2 |=> out_valid && out_hs == $past(hs2) && out_vs == $past(vs2));

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && v2 && !ovl2 |=> out_pix == $past(vid2));

  // R9
  zero_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && v2 && a2 == 8'd0 |=> out_pix == $past(vid2));

  // R9
  full_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && v2 && ovl2 && a2 == 8'd255 |=> out_pix == $past(col2));
endmodule

// File: tb/test_tile_plane_mixer.sv
`timescale 1ns/100ps
module test_tile_plane_mixer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [7:0]   glob_alpha = 8'd0;
  logic [191:0] palette;
  logic [23:0]  in_pix = '0;
  logic         in_hs = 1'b0, in_vs = 1'b0, in_ovl = 1'b0, in_valid = 1'b0;
  logic [7:0]   in_tile = '0;
  logic [2:0]   in_col = '0, in_row = '0;
  logic         out_ready = 1'b1;
  logic         in_ready, out_hs, out_vs, out_valid;
  logic         in_ready_n, out_hs_n, out_vs_n, out_valid_n;
  logic [23:0]  out_pix, out_pix_n;

  logic [23:0] pal [8];
  initial begin
    pal[0] = 24'hFF8000; pal[1] = 24'h00FF00; pal[2] = 24'h0000FF; pal[3] = 24'hFFFFFF;
    pal[4] = 24'h000000; pal[5] = 24'h804020; pal[6] = 24'h12C37E; pal[7] = 24'hA5015A;
  end
  always_comb for (int i = 0; i < 8; i++) palette[24*i +: 24] = pal[i];

  tile_plane_mixer #(.TILE_LOG2(3), .USE_ALPHA(1'b1)) i_tile_plane_mixer (
    .clk, .rst_n, .mode, .glob_alpha, .palette, .in_pix, .in_hs, .in_vs, .in_ovl,
    .in_tile, .in_col, .in_row, .in_valid, .in_ready, .out_pix, .out_hs, .out_vs,
    .out_valid, .out_ready);

  tile_plane_mixer #(.TILE_LOG2(3), .USE_ALPHA(1'b0)) i_tile_plane_mixer_rep (
    .clk, .rst_n, .mode, .glob_alpha, .palette, .in_pix, .in_hs, .in_vs, .in_ovl,
    .in_tile, .in_col, .in_row, .in_valid, .in_ready(in_ready_n), .out_pix(out_pix_n),
    .out_hs(out_hs_n), .out_vs(out_vs_n), .out_valid(out_valid_n), .out_ready);

  int checks = 0, errors = 0;

  function automatic logic [7:0] mixc(int a, int g, int v);
    return 8'((a * g + (255 - a) * v + 127) / 255);
  endfunction

  function automatic logic [23:0] model(bit use_a, logic [1:0] m, logic [7:0] t,
      logic [2:0] c, logic [2:0] r, logic [7:0] ga, bit ovl, logic [23:0] v);
    int code, a;
    logic [23:0] g;
    if (!ovl) return v;
    code = (3 * t + c + 2 * r) % 8;
    g = pal[code];
    a = use_a ? ga : 255;
    if (m == 2'd0) begin
      g = pal[0];
      a = use_a ? (code * 255 + 3) / 7 : 255;
    end else if (m == 2'd2 && code == 0) a = 0;
    return {mixc(a, g[23:16], v[23:16]), mixc(a, g[15:8], v[15:8]), mixc(a, g[7:0], v[7:0])};
  endfunction

  function automatic string tagof(bit use_a, logic [1:0] m, bit ovl);
    if (!ovl) return "R5";
    if (!use_a) return "R10 R2";
    case (m)
      2'd0: return "R6 R2 R9";
      2'd2: return "R8 R2 R9";
      default: return "R7 R2 R9";
    endcase
  endfunction

  logic [23:0] e_pix [4096], e_rep [4096];
  logic        e_hs [4096], e_vs [4096];
  string       e_tag [4096], e_tagn [4096];
  int wr = 0, rd = 0;

  logic [23:0] held_pix;
  logic        held = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (held) begin
      checks++;
      if (out_pix !== held_pix || !out_valid) begin
        errors++;
        $display("FAIL R4 stalled output moved: got %h expected %h", out_pix, held_pix);
      end
    end
    held = out_valid && !out_ready;
    held_pix = out_pix;
    if (out_valid && out_ready) begin
      checks++;
      if (rd >= wr) begin
        errors++;
        $display("FAIL R3 extra output: got %h expected none", out_pix);
      end else begin
        if (out_pix !== e_pix[rd]) begin
          errors++;
          $display("FAIL %s pixel %0d: got %h expected %h", e_tag[rd], rd, out_pix, e_pix[rd]);
        end
        checks++;
        if (out_pix_n !== e_rep[rd] || !out_valid_n) begin
          errors++;
          $display("FAIL %s pixel %0d: got %h expected %h", e_tagn[rd], rd, out_pix_n, e_rep[rd]);
        end
        checks++;
        if (out_hs !== e_hs[rd] || out_vs !== e_vs[rd]) begin
          errors++;
          $display("FAIL R3 sync pixel %0d: got %b%b expected %b%b", rd, out_hs, out_vs, e_hs[rd], e_vs[rd]);
        end
        rd++;
      end
    end
    if (in_valid && in_ready) begin
      e_pix[wr] = model(1'b1, mode, in_tile, in_col, in_row, glob_alpha, in_ovl, in_pix);
      e_rep[wr] = model(1'b0, mode, in_tile, in_col, in_row, glob_alpha, in_ovl, in_pix);
      e_tag[wr] = tagof(1'b1, mode, in_ovl);
      e_tagn[wr] = tagof(1'b0, mode, in_ovl);
      e_hs[wr] = in_hs;
      e_vs[wr] = in_vs;
      wr++;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  bit stalls = 1'b0;
  always @(posedge clk) begin
    #0.5;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stalls ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] seed = 32'h1234_5678;
  task automatic send(logic [7:0] t, logic [2:0] c, logic [2:0] r);
    bit done = 1'b0;
    seed = seed * 32'd1664525 + 32'd1013904223;
    in_pix = seed[31:8];
    in_ovl = (seed[3:0] != 4'd0);
    in_hs = (c == 3'd0);
    in_vs = (c == 3'd0) && (r == 3'd0);
    in_tile = t; in_col = c; in_row = r;
    in_valid = 1'b1;
    while (!done) begin
      @(negedge clk);
      done = in_ready;
      @(posedge clk);
      #1;
    end
    if (seed[6:4] == 3'd0) begin
      in_valid = 1'b0;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (rd < wr) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    logic [7:0] gas [4];
    gas[0] = 8'd0; gas[1] = 8'd255; gas[2] = 8'd128; gas[3] = 8'd77;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: got valid %b ready %b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk);
    #1;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        mode = 2'(m);
        glob_alpha = gas[k];
        stalls = (k >= 2);
        for (int t = 0; t < 4; t++)
          for (int r = 0; r < 8; r += 5)
            for (int c = 0; c < 8; c++)
              send(8'(t * 37 + m), 3'(c), 3'(r));
        drain();
      end
    end
    repeat (5) @(posedge clk);
    // R3
    checks++;
    if (rd != wr || out_valid) begin
      errors++;
      $display("FAIL R3 count: got %0d outputs expected %0d", rd, wr);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule